// File: doc/BRIEF.md
# Bootloader Command Packet Responder

This block sits on the byte path of a serial slave that is used for firmware download. It takes one received byte per strobe. It groups the bytes into command packets, each made of a length byte, a checksum byte and a payload whose first byte is the command code. It checks the additive checksum and decodes the command. It then arms a two-byte reply, or a three-byte reply for a status query, which the host drains one byte per read strobe. A status code is kept across packets and is returned by the status query.

For firmware transfer, a download command records a start address and a byte budget, after checking both against the memory size. Each data byte of a later send-data command is passed on as a write strobe carrying its target address. The address and the remaining budget move forward only when the packet is accepted. Erase, programming and the physical bus engine sit outside the block.

Top module: `bootpkt_responder`

## Requirements
- R1: The length byte counts the whole packet, including itself and the checksum byte. A packet is good when the checksum byte equals the low 8 bits of the sum of all payload bytes. A packet that fails this check is answered 0x00, 0x33 (negative) and changes neither the status nor the download state.
- R2: A good ping packet (payload 0x20 alone, length 3) is answered 0x00, 0xCC (positive) and sets the status to 0x40.
- R3: A good status query (payload 0x23 alone) is answered 0x00, 0xCC and then the current status byte, and leaves the status unchanged.
- R4: A good packet with an unrecognised command code is answered negative and sets the status to 0x41. A ping or status query of the wrong length, or a download whose length is not 11, is answered negative and sets the status to 0x42.
- R5: A good download packet (0x21, a 4-byte start address and then a 4-byte byte count, each most significant byte first) is accepted when the address is a multiple of 4 and address plus count does not exceed MEM_BYTES. An accepted download is answered positive, sets the status to 0x40 and arms data transfer at that address with that budget.
- R6: A download that breaks the alignment or size rule is answered negative, sets the status to 0x43 and disarms data transfer.
- R7: In an armed send-data packet (0x24 followed by data bytes), each data byte produces one write strobe one cycle after the byte. The strobes carry consecutive addresses starting at the current transfer address. An accepted send-data packet is answered positive, sets the status to 0x40 and advances the address and budget by its data count.
- R8: A send-data packet that arrives while transfer is disarmed, carries no data, or carries more bytes than the remaining budget produces no write strobe. It is answered negative and sets the status to 0x42.
- R9: A send-data packet that fails the checksum is answered negative and does not advance the address, so a resent packet writes the same addresses again.
- R10: A read strobe returns the next reply byte on tx_data one cycle later. A read made when no reply byte is pending returns 0x00. tx_data changes only after a read strobe.
- R11: When a reply is armed in the same cycle as a read, that read is served from the previous reply state, and the new reply is then read out from its first byte.
- R12: A length byte below 3 is answered negative at once, and the next byte is taken as a new length byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A received byte is present on rx_data |
| rx_data | input | 8 | Received byte |
| tx_rd | input | 1 | Host read strobe for one reply byte |
| tx_data | output | 8 | Reply byte, valid the cycle after tx_rd |
| wr_en | output | 1 | Write strobe for one data byte |
| wr_addr | output | ADDR_W | Target address of the write |
| wr_data | output | 8 | Data byte to write |

## Verification
Two events can fall in the same cycle: a host read draining the old reply, and the last byte of a new packet arming a fresh reply. The bench provokes this by leaving a status reply partly read and then asserting the read strobe on the cycle that carries the final byte of a ping. That read must return the next byte of the old reply. The following reads must return the ping's 0x00, 0xCC from the start, followed by 0x00 filler.

// File: rtl/bootpkt_pkg.sv
package bootpkt_pkg;
  localparam logic [7:0] CMD_PING = 8'h20;
  localparam logic [7:0] CMD_DNLD = 8'h21;
  localparam logic [7:0] CMD_STAT = 8'h23;
  localparam logic [7:0] CMD_DATA = 8'h24;

  localparam logic [7:0] ST_OK     = 8'h40;
  localparam logic [7:0] ST_UNK    = 8'h41;
  localparam logic [7:0] ST_BADCMD = 8'h42;
  localparam logic [7:0] ST_BADADR = 8'h43;

  localparam logic [7:0] REP_LEAD = 8'h00;
  localparam logic [7:0] REP_ACK  = 8'hCC;
  localparam logic [7:0] REP_NAK  = 8'h33;

  typedef enum logic [1:0] {FR_SIZE, FR_CKS, FR_PAY} fr_state_t;

  typedef struct packed {
    logic       ack;
    logic       with_st;
    logic [7:0] st;
  } reply_t;
endpackage

// File: rtl/pkt_framer.sv
module pkt_framer
  import bootpkt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  output logic       pay_stb,
  output logic [7:0] pay_idx,
  output logic       pay_last,
  output logic [7:0] pkt_size,
  output logic       pkt_end,
  output logic       pkt_good
);
  fr_state_t  state_q;
  logic [7:0] size_q, cks_q, sum_q, idx_q;
  logic       runt;

  always_comb begin
    pay_stb  = rx_valid && (state_q == FR_PAY);
    pay_idx  = idx_q;
    pkt_size = size_q;
    pay_last = pay_stb && (idx_q == size_q - 8'd3);
    runt     = rx_valid && (state_q == FR_SIZE) && (rx_data < 8'd3);
    pkt_end  = pay_last || runt;
    pkt_good = pay_last && (8'(sum_q + rx_data) == cks_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= FR_SIZE;
      size_q  <= 8'd0;
      cks_q   <= 8'd0;
      sum_q   <= 8'd0;
      idx_q   <= 8'd0;
    end else if (rx_valid) begin
      case (state_q)
        FR_SIZE: if (!runt) begin
          size_q  <= rx_data;
          state_q <= FR_CKS;
        end
        FR_CKS: begin
          cks_q   <= rx_data;
          sum_q   <= 8'd0;
          idx_q   <= 8'd0;
          state_q <= FR_PAY;
        end
        default: begin
          sum_q <= sum_q + rx_data;
          idx_q <= idx_q + 8'd1;
          if (pay_last) state_q <= FR_SIZE;
        end
      endcase
    end
  end
endmodule

// File: rtl/cmd_engine.sv
module cmd_engine
  import bootpkt_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MEM_BYTES = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        rx_data,
  input  logic              pay_stb,
  input  logic [7:0]        pay_idx,
  input  logic [7:0]        pkt_size,
  input  logic              pkt_end,
  input  logic              pkt_good,
  output logic              rep_stb,
  output reply_t            rep,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              armed
);
  localparam int LEN_W = 32;
  localparam int ARG_W = 2 * LEN_W;

  logic [7:0]        cmd_q, status_q, cur_cmd, n_data, off;
  logic [ARG_W-1:0]  arg_q, full_arg;
  logic              data_ok_q, data_ok_now, data_ok, armed_q;
  logic [ADDR_W-1:0] next_q;
  logic [LEN_W-1:0]  left_q, dl_a, dl_l;
  logic              fits, aligned;
  logic              st_upd, do_arm, do_disarm, do_adv;
  logic [7:0]        st_new;

  always_comb begin
    cur_cmd     = (pay_idx == 8'd0) ? rx_data : cmd_q;
    full_arg    = {arg_q[ARG_W-9:0], rx_data};
    dl_a        = full_arg[ARG_W-1:LEN_W];
    dl_l        = full_arg[LEN_W-1:0];
    aligned     = (dl_a[1:0] == 2'b00);
    fits        = ({1'b0, dl_a} + {1'b0, dl_l}) <= (LEN_W+1)'(MEM_BYTES);
    n_data      = pkt_size - 8'd3;
    off         = pay_idx - 8'd1;
    data_ok_now = (rx_data == CMD_DATA) && armed_q && (pkt_size >= 8'd4)
                  && (LEN_W'(n_data) <= left_q);
    data_ok     = (pay_idx == 8'd0) ? data_ok_now : data_ok_q;

    rep       = '{ack: 1'b0, with_st: 1'b0, st: status_q};
    st_upd    = 1'b0;
    st_new    = status_q;
    do_arm    = 1'b0;
    do_disarm = 1'b0;
    do_adv    = 1'b0;
    if (pkt_good) begin
      st_upd = 1'b1;
      case (cur_cmd)
        CMD_PING: begin
          rep.ack = (pkt_size == 8'd3);
          st_new  = rep.ack ? ST_OK : ST_BADCMD;
        end
        CMD_STAT: begin
          rep.ack     = (pkt_size == 8'd3);
          rep.with_st = rep.ack;
          st_upd      = !rep.ack;
          st_new      = ST_BADCMD;
        end
        CMD_DNLD: begin
          if (pkt_size != 8'd11) begin
            st_new = ST_BADCMD;
          end else if (aligned && fits) begin
            rep.ack = 1'b1;
            st_new  = ST_OK;
            do_arm  = 1'b1;
          end else begin
            st_new    = ST_BADADR;
            do_disarm = 1'b1;
          end
        end
        CMD_DATA: begin
          rep.ack = data_ok;
          do_adv  = data_ok;
          st_new  = data_ok ? ST_OK : ST_BADCMD;
        end
        default: st_new = ST_UNK;
      endcase
    end
    rep_stb = pkt_end;
    armed   = armed_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q     <= 8'd0;
      arg_q     <= '0;
      data_ok_q <= 1'b0;
      armed_q   <= 1'b0;
      next_q    <= '0;
      left_q    <= '0;
      status_q  <= ST_OK;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= 8'd0;
    end else begin
      wr_en <= 1'b0;
      if (pay_stb) begin
        if (pay_idx == 8'd0) begin
          cmd_q     <= rx_data;
          data_ok_q <= data_ok_now;
        end else begin
          arg_q <= full_arg;
          if (cmd_q == CMD_DATA && data_ok_q) begin
            wr_en   <= 1'b1;
            wr_addr <= next_q + ADDR_W'(off);
            wr_data <= rx_data;
          end
        end
      end
      if (st_upd) status_q <= st_new;
      if (do_arm) begin
        armed_q <= 1'b1;
        next_q  <= dl_a[ADDR_W-1:0];
        left_q  <= dl_l;
      end
      if (do_disarm) armed_q <= 1'b0;
      if (do_adv) begin
        next_q <= next_q + ADDR_W'(n_data);
        left_q <= left_q - LEN_W'(n_data);
      end
    end
  end
endmodule

// File: rtl/reply_tx.sv
module reply_tx
  import bootpkt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rep_stb,
  input  reply_t     rep,
  input  logic       tx_rd,
  output logic [7:0] tx_data,
  output logic       pending
);
  logic [1:0] len_q, idx_q;
  logic [7:0] b1_q, b2_q, cur;

  always_comb begin
    pending = (idx_q < len_q);
    case (idx_q)
      2'd0:    cur = REP_LEAD;
      2'd1:    cur = b1_q;
      default: cur = b2_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q   <= 2'd0;
      idx_q   <= 2'd0;
      b1_q    <= 8'd0;
      b2_q    <= 8'd0;
      tx_data <= 8'd0;
    end else begin
      if (tx_rd) begin
        tx_data <= pending ? cur : 8'h00;
        if (pending) idx_q <= idx_q + 2'd1;
      end
      if (rep_stb) begin
        len_q <= rep.with_st ? 2'd3 : 2'd2;
        idx_q <= 2'd0;
        b1_q  <= rep.ack ? REP_ACK : REP_NAK;
        b2_q  <= rep.st;
      end
    end
  end
endmodule

// File: rtl/bootpkt_responder.sv
module bootpkt_responder
  import bootpkt_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MEM_BYTES = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              tx_rd,
  output logic [7:0]        tx_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);
  logic       pay_stb, pay_last, pkt_end, pkt_good, rep_stb, armed, rep_pending;
  logic [7:0] pay_idx, pkt_size;
  reply_t     rep;

  pkt_framer u_framer (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .pay_stb(pay_stb), .pay_idx(pay_idx), .pay_last(pay_last),
    .pkt_size(pkt_size), .pkt_end(pkt_end), .pkt_good(pkt_good)
  );

  cmd_engine #(.ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES)) u_engine (
    .clk(clk), .rst(rst), .rx_data(rx_data), .pay_stb(pay_stb),
    .pay_idx(pay_idx), .pkt_size(pkt_size), .pkt_end(pkt_end),
    .pkt_good(pkt_good), .rep_stb(rep_stb), .rep(rep), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .armed(armed)
  );

  reply_tx u_reply (
    .clk(clk), .rst(rst), .rep_stb(rep_stb), .rep(rep), .tx_rd(tx_rd),
    .tx_data(tx_data), .pending(rep_pending)
  );
endmodule

// File: rtl/bootpkt_responder_chk.sv
module bootpkt_responder_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_valid,
  input logic              tx_rd,
  input logic [7:0]        tx_data,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              armed,
  input logic              pending
);
  AST_WR_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(rx_valid)); // R7

  AST_WR_CONSECUTIVE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + ADDR_W'(1))); // R7

  AST_WR_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(armed)); // R8

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tx_rd |=> $stable(tx_data)); // R10

  AST_TX_FILLER: assert property (@(posedge clk) disable iff (rst)
    (tx_rd && !pending) |=> (tx_data == 8'h00)); // R10
endmodule

bind bootpkt_responder bootpkt_responder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .tx_rd(tx_rd),
  .tx_data(tx_data), .wr_en(wr_en), .wr_addr(wr_addr), .armed(armed),
  .pending(rep_pending)
);

// File: tb/sim_bootpkt_responder.sv
module sim_bootpkt_responder;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              rx_valid = 1'b0;
  logic [7:0]        rx_data = 8'd0;
  logic              tx_rd = 1'b0;
  logic [7:0]        tx_data;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0]        pl [0:11];
  int                pn;
  logic [ADDR_W-1:0] wa [0:31];
  logic [7:0]        wd [0:31];
  int                wn = 0;

  bootpkt_responder #(.ADDR_W(ADDR_W), .MEM_BYTES(1024)) u0 (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_rd(tx_rd), .tx_data(tx_data), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (!rst && wr_en && wn < 32) begin
      wa[wn] = wr_addr;
      wd[wn] = wr_data;
      wn++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send_pkt(input logic bad);
    logic [7:0] s = 8'd0;
    for (int i = 0; i < pn; i++) s = s + pl[i];
    put_byte(8'(pn + 2));
    put_byte(bad ? (s ^ 8'h01) : s);
    for (int i = 0; i < pn; i++) put_byte(pl[i]);
  endtask

  task automatic get_byte(output logic [7:0] b);
    @(negedge clk);
    tx_rd = 1'b1;
    @(negedge clk);
    tx_rd = 1'b0;
    b = tx_data;
  endtask

  task automatic expect_rep(input string tag, input logic [7:0] code);
    logic [7:0] b;
    get_byte(b); chk(tag, {24'd0, b}, 32'h00);
    get_byte(b); chk(tag, {24'd0, b}, {24'd0, code});
  endtask

  task automatic expect_status(input string tag, input logic [7:0] st);
    logic [7:0] b;
    pl[0] = 8'h23; pn = 1; send_pkt(1'b0);
    expect_rep(tag, 8'hCC);
    get_byte(b); chk(tag, {24'd0, b}, {24'd0, st});
  endtask

  task automatic set_dl(input logic [31:0] a, input logic [31:0] l);
    pl[0] = 8'h21;
    for (int i = 0; i < 4; i++) begin
      pl[1+i] = a[31-8*i -: 8];
      pl[5+i] = l[31-8*i -: 8];
    end
    pn = 9;
  endtask

  task automatic t_reset;
    logic [7:0] b;
    chk("R10 reset wr_en", {31'd0, wr_en}, 32'd0);
    get_byte(b); chk("R10 filler after reset", {24'd0, b}, 32'h00);
    expect_status("R3 status after reset", 8'h40);
  endtask

  task automatic t_ping;
    logic [7:0] b;
    pl[0] = 8'h20; pn = 1; send_pkt(1'b0);
    expect_rep("R2 ping ack", 8'hCC);
    get_byte(b); chk("R10 filler after reply", {24'd0, b}, 32'h00);
  endtask

  task automatic t_errors;
    pl[0] = 8'h55; pn = 1; send_pkt(1'b0);
    expect_rep("R4 unknown nak", 8'h33);
    expect_status("R4 unknown status", 8'h41);
    pl[0] = 8'h20; pn = 1; send_pkt(1'b1);
    expect_rep("R1 bad checksum nak", 8'h33);
    expect_status("R1 status unchanged", 8'h41);
    pl[0] = 8'h20; pl[1] = 8'h00; pn = 2; send_pkt(1'b0);
    expect_rep("R4 long ping nak", 8'h33);
    expect_status("R4 long ping status", 8'h42);
  endtask

  task automatic t_runt;
    put_byte(8'h02);
    expect_rep("R12 runt nak", 8'h33);
    pl[0] = 8'h20; pn = 1; send_pkt(1'b0);
    expect_rep("R12 resync ping", 8'hCC);
  endtask

  task automatic t_download;
    pl[0] = 8'h24; pl[1] = 8'hAA; pn = 2; send_pkt(1'b0);
    expect_rep("R8 unarmed nak", 8'h33);
    expect_status("R8 unarmed status", 8'h42);
    chk("R8 unarmed no write", wn, 0);
    set_dl(32'h102, 32'h4); send_pkt(1'b0);
    expect_rep("R6 misaligned nak", 8'h33);
    expect_status("R6 misaligned status", 8'h43);
    set_dl(32'h3F0, 32'h20); send_pkt(1'b0);
    expect_rep("R6 oversize nak", 8'h33);
    set_dl(32'h3F8, 32'h8); send_pkt(1'b0);
    expect_rep("R5 exact fit ack", 8'hCC);
    set_dl(32'h100, 32'h6); send_pkt(1'b0);
    expect_rep("R5 download ack", 8'hCC);
    expect_status("R5 download status", 8'h40);
  endtask

  task automatic t_data;
    int w0;
    pl[0] = 8'h24; pl[1] = 8'h11; pl[2] = 8'h22; pl[3] = 8'h33; pl[4] = 8'h44;
    pn = 5; send_pkt(1'b0);
    expect_rep("R7 data ack", 8'hCC);
    chk("R7 write count", wn, 4);
    for (int i = 0; i < 4; i++) begin
      chk("R7 write addr", wa[i], 32'h100 + i);
      chk("R7 write data", {24'd0, wd[i]}, {24'd0, pl[1+i]});
    end
    w0 = wn;
    pl[0] = 8'h24; pl[1] = 8'h01; pl[2] = 8'h02; pl[3] = 8'h03; pn = 4; send_pkt(1'b0);
    expect_rep("R8 over budget nak", 8'h33);
    expect_status("R8 over budget status", 8'h42);
    chk("R8 over budget no write", wn, w0);
    pl[0] = 8'h24; pl[1] = 8'h55; pl[2] = 8'h66; pn = 3; send_pkt(1'b1);
    expect_rep("R9 data bad checksum", 8'h33);
    pl[0] = 8'h24; pl[1] = 8'h77; pl[2] = 8'h88; pn = 3; send_pkt(1'b0);
    expect_rep("R9 resend ack", 8'hCC);
    chk("R9 write count", wn, w0 + 4);
    chk("R9 resend addr", wa[w0+2], 32'h104);
    chk("R9 resend addr2", wa[w0+3], 32'h105);
    chk("R9 first try addr", wa[w0], 32'h104);
    chk("R9 resend data", {24'd0, wd[w0+3]}, 32'h88);
  endtask

  task automatic t_collide;
    logic [7:0] b;
    pl[0] = 8'h23; pn = 1; send_pkt(1'b0);
    get_byte(b); chk("R11 old reply lead", {24'd0, b}, 32'h00);
    put_byte(8'h03);
    put_byte(8'h20);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'h20; tx_rd = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; tx_rd = 1'b0;
    chk("R11 read served from old reply", {24'd0, tx_data}, 32'hCC);
    expect_rep("R11 new reply from start", 8'hCC);
    get_byte(b); chk("R11 filler after new reply", {24'd0, b}, 32'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_ping;
    t_errors;
    t_runt;
    t_download;
    t_data;
    t_collide;
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule